// File: doc/BRIEF.md
# Chained Byte Adder-Subtractor

This combinational datapath adds or subtracts two bytes, one slice of a wider number at a time. A two-bit operation code picks one of four operations: plain add, add with pending carry, plain subtract, or subtract with pending borrow. The unit inverts the second operand for subtraction and picks the adder's carry-in from the operation code and an externally held flag.

The unit returns a result byte and a flag. The surrounding logic stores that flag and feeds it back in with the next more-significant byte. A wide addition is therefore one plain add followed by a string of add-with-carry operations. A wide subtraction is one plain subtract followed by subtract-with-borrow operations. For subtraction the flag is a borrow: 1 means the subtrahend exceeded the minuend, taken as unsigned.

Top module: `addsub_chain_unit`

## Requirements
- R1: With func = 2'b00, result is (opnd_a + opnd_b) mod 256 and flag_out is the carry out of bit 7.
- R2: With func = 2'b01, result is (opnd_a + opnd_b + flag_in) mod 256 and flag_out is 1 exactly when that sum exceeds 255.
- R3: With func = 2'b10, result is (opnd_a - opnd_b) mod 256 and flag_out is 1 exactly when opnd_b > opnd_a (unsigned).
- R4: With func = 2'b11, result is (opnd_a - opnd_b - flag_in) mod 256 and flag_out is 1 exactly when opnd_b + flag_in > opnd_a (unsigned).
- R5: For func = 2'b00 and func = 2'b10, the value of flag_in has no effect on result or flag_out.
- R6: Feeding flag_out of the low byte into flag_in of the high byte, one add then one add-with-carry (or one subtract then one subtract-with-borrow) yields the correct 16-bit sum (or difference) and a correct final carry (or borrow).
- R7: At the full-width boundaries the flag is raised: 0xFF + 0x01 gives 0x00 with carry, 0x00 - 0x01 gives 0xFF with borrow, and an equal-operand subtract-with-borrow under a pending borrow gives 0xFF with borrow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 8 | First operand (minuend for subtraction) |
| opnd_b | input | 8 | Second operand (subtrahend for subtraction) |
| flag_in | input | 1 | Stored carry/borrow from the previous byte |
| func | input | 2 | Operation select: 00 add, 01 add with carry, 10 subtract, 11 subtract with borrow |
| result | output | 8 | Result byte |
| flag_out | output | 1 | Carry (add) or borrow (subtract) to be stored for the next byte |

## Verification
The bench targets the carry-in choice and the flag polarity. A design that passed the stored flag straight into the adder on subtract-with-borrow would subtract one too few when a borrow is pending and one too many when none is. A design that reported the raw adder carry on subtraction would show borrow on equal operands and none on 0x00 - 0x01. Plain add and subtract run with flag_in set to catch a flag leaking where it must be ignored. Two-byte chains check that the low byte's flag, fed back unchanged, completes the wide result.

// File: rtl/addsub_chain_pkg.sv
// Package: shared operation encoding for the chained adder-subtractor.
// Assumes the two-bit code layout is fixed: bit 1 selects subtract, bit 0 selects
// use of the stored flag.
package addsub_chain_pkg;

    typedef enum logic [1:0] {
        FN_ADD = 2'b00,
        FN_ADC = 2'b01,
        FN_SUB = 2'b10,
        FN_SBB = 2'b11
    } addsub_fn_e;

endpackage

// File: rtl/asu_operand_cond.sv
// Module: conditions the second operand, passing it through for additions and
// producing its ones' complement for subtractions.
// Assumes inv is already decoded from the operation code.
module asu_operand_cond #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] raw_b,
    input  logic             inv,
    output logic [WIDTH-1:0] cond_b
);

    // Per-bit conditional inversion.
    always_comb begin
        cond_b = raw_b ^ {WIDTH{inv}};
    end

endmodule

// File: rtl/asu_carry_select.sv
// Module: decodes the operation code into the operand-invert control, the adder
// carry-in and the flag-polarity control.
// Assumes the stored flag means carry after additions and borrow after subtractions.
module asu_carry_select
    import addsub_chain_pkg::*;
(
    input  addsub_fn_e fn,
    input  logic       flag_in,
    output logic       inv_b,
    output logic       carry_in,
    output logic       flag_neg
);

    // Select carry-in and polarity for each operation.
    always_comb begin
        unique case (fn)
            FN_ADD:  begin inv_b = 1'b0; carry_in = 1'b0;     flag_neg = 1'b0; end
            FN_ADC:  begin inv_b = 1'b0; carry_in = flag_in;  flag_neg = 1'b0; end
            FN_SUB:  begin inv_b = 1'b1; carry_in = 1'b1;     flag_neg = 1'b1; end
            default: begin inv_b = 1'b1; carry_in = ~flag_in; flag_neg = 1'b1; end
        endcase
    end

endmodule

// File: rtl/asu_ripple_adder.sv
// Module: ripple-carry adder built from one full-adder cell per bit.
// Assumes WIDTH >= 1; the carry chain depth grows linearly with WIDTH.
module asu_ripple_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    logic [WIDTH:0] chain;

    // Seed the carry chain.
    always_comb begin
        chain[0] = cin;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        // One full-adder cell: sum bit and carry to the next position.
        always_comb begin
            sum[i]     = x[i] ^ y[i] ^ chain[i];
            chain[i+1] = (x[i] & y[i]) | (chain[i] & (x[i] ^ y[i]));
        end
    end

    // Carry out of the top cell.
    always_comb begin
        cout = chain[WIDTH];
    end

endmodule

// File: rtl/addsub_chain_unit.sv
// Module: top of the chained adder-subtractor; one byte slice of a wider add or
// subtract, with the carry/borrow flag kept by the caller between slices.
// Assumes purely combinational use; outputs follow inputs within one cycle.
module addsub_chain_unit
    import addsub_chain_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             flag_in,
    input  logic [1:0]       func,
    output logic [WIDTH-1:0] result,
    output logic             flag_out
);

    addsub_fn_e      fn;
    logic            inv_b;
    logic            carry_in;
    logic            flag_neg;
    logic [WIDTH-1:0] cond_b;
    logic            adder_cout;

    // Map the raw code onto the shared encoding.
    always_comb begin
        fn = addsub_fn_e'(func);
    end

    asu_carry_select u_csel (
        .fn       (fn),
        .flag_in  (flag_in),
        .inv_b    (inv_b),
        .carry_in (carry_in),
        .flag_neg (flag_neg)
    );

    asu_operand_cond #(.WIDTH(WIDTH)) u_cond (
        .raw_b  (opnd_b),
        .inv    (inv_b),
        .cond_b (cond_b)
    );

    asu_ripple_adder #(.WIDTH(WIDTH)) u_add (
        .x    (opnd_a),
        .y    (cond_b),
        .cin  (carry_in),
        .sum  (result),
        .cout (adder_cout)
    );

    // Turn the adder carry into a borrow for subtractions.
    always_comb begin
        flag_out = adder_cout ^ flag_neg;
    end

endmodule

// File: rtl/addsub_chain_chk.sv
// Module: checker comparing the port behaviour with wide reference arithmetic.
// Assumes inputs are stable whenever the combinational block is evaluated.
module addsub_chain_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic             flag_in,
    input logic [1:0]       func,
    input logic [WIDTH-1:0] result,
    input logic             flag_out
);

    logic [WIDTH:0] ref_sum;
    logic [WIDTH:0] ref_sub;
    logic [WIDTH:0] b_plus;

    // Reference values and checks for each operation.
    always_comb begin
        ref_sum = {1'b0, opnd_a} + {1'b0, opnd_b} + ((func == 2'b01) ? {{WIDTH{1'b0}}, flag_in} : '0);
        b_plus  = {1'b0, opnd_b} + ((func == 2'b11) ? {{WIDTH{1'b0}}, flag_in} : '0);
        ref_sub = {1'b0, opnd_a} - b_plus;
        if (func == 2'b00) begin
            assert_add_R1: assert ({flag_out, result} == ref_sum)
                else $error("R1 add mismatch");
        end
        if (func == 2'b01) begin
            assert_adc_R2: assert ({flag_out, result} == ref_sum)
                else $error("R2 add-with-carry mismatch");
        end
        if (func == 2'b10) begin
            assert_sub_R3: assert (result == ref_sub[WIDTH-1:0] && flag_out == (b_plus > {1'b0, opnd_a}))
                else $error("R3 subtract mismatch");
        end
        if (func == 2'b11) begin
            assert_sbb_R4: assert (result == ref_sub[WIDTH-1:0] && flag_out == (b_plus > {1'b0, opnd_a}))
                else $error("R4 subtract-with-borrow mismatch");
        end
    end

endmodule

bind addsub_chain_unit addsub_chain_chk #(.WIDTH(WIDTH)) u_chk (
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .flag_in  (flag_in),
    .func     (func),
    .result   (result),
    .flag_out (flag_out)
);

// File: tb/tb_addsub_chain_unit.sv
module tb_addsub_chain_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic       flag_in = 1'b0;
    logic [1:0] func = 2'b00;
    logic [7:0] result;
    logic       flag_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    addsub_chain_unit dut (
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .flag_in  (flag_in),
        .func     (func),
        .result   (result),
        .flag_out (flag_out)
    );

    // {func, flag_in, a, b, expected result, expected flag}
    localparam int NV = 15;
    localparam logic [27:0] VEC [NV] = '{
        {2'b00, 1'b0, 8'h88, 8'hC4, 8'h4C, 1'b1},  // R1
        {2'b01, 1'b1, 8'h13, 8'h09, 8'h1D, 1'b0},  // R2
        {2'b00, 1'b1, 8'h10, 8'h20, 8'h30, 1'b0},  // R5
        {2'b01, 1'b0, 8'hFF, 8'h00, 8'hFF, 1'b0},  // R2
        {2'b01, 1'b1, 8'hFF, 8'h00, 8'h00, 1'b1},  // R2
        {2'b10, 1'b0, 8'h50, 8'h30, 8'h20, 1'b0},  // R3
        {2'b10, 1'b1, 8'h30, 8'h50, 8'hE0, 1'b1},  // R3 R5
        {2'b11, 1'b1, 8'h50, 8'h30, 8'h1F, 1'b0},  // R4
        {2'b11, 1'b0, 8'h30, 8'h30, 8'h00, 1'b0},  // R4
        {2'b11, 1'b1, 8'h30, 8'h30, 8'hFF, 1'b1},  // R7
        {2'b00, 1'b0, 8'hFF, 8'h01, 8'h00, 1'b1},  // R7
        {2'b10, 1'b0, 8'h00, 8'h01, 8'hFF, 1'b1},  // R7
        {2'b10, 1'b1, 8'h7F, 8'h7F, 8'h00, 1'b0},  // R3 R5
        {2'b11, 1'b1, 8'h00, 8'hFF, 8'h00, 1'b1},  // R4
        {2'b01, 1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b1}   // R2
    };

    task automatic apply(input logic [1:0] f, input logic fi, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        func = f; flag_in = fi; opnd_a = a; opnd_b = b;
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [7:0] er, input logic ef);
        total++;
        if (result !== er || flag_out !== ef) begin
            bad++;
            $display("FAIL %s: got result=%h flag=%b expected result=%h flag=%b", req, result, flag_out, er, ef);
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic       f_lo;
        logic [7:0] r_lo;
        // Idle state with all inputs low: add of zeros (R1).
        repeat (2) @(posedge clk);
        #2;
        check("R1 idle", 8'h00, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][27:26], VEC[i][25], VEC[i][24:17], VEC[i][16:9]);
            check($sformatf("vector %0d (R1-R5,R7 table)", i), VEC[i][8:1], VEC[i][0]);
        end

        // R5: flag_in toggled under plain add and subtract leaves outputs unchanged.
        apply(2'b00, 1'b0, 8'hA5, 8'h6C);
        check("R5 add fi=0", 8'h11, 1'b1);
        apply(2'b00, 1'b1, 8'hA5, 8'h6C);
        check("R5 add fi=1", 8'h11, 1'b1);
        apply(2'b10, 1'b1, 8'h05, 8'h09);
        check("R5 sub fi=1", 8'hFC, 1'b1);

        // R6: 16-bit add 0x1388 + 0x09C4 = 0x1D4C.
        apply(2'b00, 1'b0, 8'h88, 8'hC4);
        r_lo = result; f_lo = flag_out;
        apply(2'b01, f_lo, 8'h13, 8'h09);
        check("R6 add high", 8'h1D, 1'b0);
        total++;
        if (r_lo !== 8'h4C) begin
            bad++;
            $display("FAIL R6 add low: got %h expected 4c", r_lo);
        end

        // R6: 16-bit subtract 0x1000 - 0x0001 = 0x0FFF.
        apply(2'b10, 1'b0, 8'h00, 8'h01);
        r_lo = result; f_lo = flag_out;
        apply(2'b11, f_lo, 8'h10, 8'h00);
        check("R6 sub high", 8'h0F, 1'b0);
        total++;
        if (r_lo !== 8'hFF) begin
            bad++;
            $display("FAIL R6 sub low: got %h expected ff", r_lo);
        end

        // R6: 16-bit subtract 0x0000 - 0x0001 borrows out.
        apply(2'b10, 1'b0, 8'h00, 8'h01);
        f_lo = flag_out;
        apply(2'b11, f_lo, 8'h00, 8'h00);
        check("R6 sub final borrow", 8'hFF, 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule